// File: doc/BRIEF.md
# Integer Compare and Branch-Condition Unit

A purely combinational unit for a 64-bit integer datapath. It takes two operands and a 3-bit operation code. It returns two things: a set-less-than result, zero-extended to the full register width, and a branch-taken flag.

The operation code uses the standard integer funct3 numbering, so a decoder can pass the field through unchanged. The codes 010 and 011 select the set-less-than forms. The other six codes select branch conditions.

Immediate variants need no separate path. The caller sign-extends the 12-bit immediate to 64 bits and presents it as operand B. This applies to the unsigned form as well.

Branch target arithmetic, program-counter update and instruction decode belong to neighbouring blocks.

Top module: `int_cmp_unit`

## Requirements
- R1: Code 010 (signed set-less-than) sets bit 0 of `slt_o` to 1 exactly when A < B with both operands read as two's-complement numbers.
- R2: Code 011 (unsigned set-less-than) sets bit 0 of `slt_o` to 1 exactly when A < B with both operands read as unsigned numbers. This includes a B that is a sign-extended negative immediate, which reads as a very large unsigned value.
- R3: Bits 63 down to 1 of `slt_o` are always 0.
- R4: For the six branch codes, `slt_o` is all zeros. For codes 010 and 011, `taken_o` is 0.
- R5: Code 000 raises `taken_o` exactly when A equals B.
- R6: Code 001 raises `taken_o` exactly when A differs from B.
- R7: Code 100 raises `taken_o` exactly when A < B as signed numbers.
- R8: Code 101 raises `taken_o` exactly when A >= B as signed numbers, which is the complement of code 100.
- R9: Code 110 raises `taken_o` exactly when A < B as unsigned numbers.
- R10: Code 111 raises `taken_o` exactly when A >= B as unsigned numbers, which is the complement of code 110.
- R11: Across the sign boundary, the most negative value (bit 63 set, all other bits 0) compared against zero is less-than in the signed codes and greater in the unsigned codes.
- R12: With equal operands, every less-than form gives 0, every greater-or-equal form gives 1, equality gives 1 and inequality gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 64 | Operand A |
| b_i | input | 64 | Operand B, or the sign-extended immediate |
| op_i | input | 3 | Operation code (funct3 numbering) |
| slt_o | output | 64 | Set-less-than result, zero-extended |
| taken_o | output | 1 | Branch condition outcome |

## Verification
The operand patterns fall into three groups, and each group separates a different kind of fault.

- Same-sign pairs with small magnitudes confirm basic ordering.
- Pairs whose sign bits differ, such as -1 against 1, or the most negative value against zero, only pass when signed and unsigned ordering are kept apart.
- Pairs that differ only across the 32-bit chunk boundary, such as 2^32 against 2^32-1, expose mistakes in the chunk-combining logic.

Equal operands are then swept through all eight codes. Each greater-or-equal condition is checked to be the exact complement of its less-than partner, and the set-less-than output must stay silent on the branch codes.

// File: rtl/int_cmp_pkg.sv
package int_cmp_pkg;
  typedef enum logic [2:0] {
    OP_BEQ  = 3'b000,
    OP_BNE  = 3'b001,
    OP_SLT  = 3'b010,
    OP_SLTU = 3'b011,
    OP_BLT  = 3'b100,
    OP_BGE  = 3'b101,
    OP_BLTU = 3'b110,
    OP_BGEU = 3'b111
  } cmp_op_e;
endpackage

// File: rtl/cmp_magnitude.sv
module cmp_magnitude #(
  parameter int WIDTH   = 64,
  parameter int CHUNK_W = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             eq_o,
  output logic             lt_s_o,
  output logic             lt_u_o
);
  localparam int NCHUNK = WIDTH / CHUNK_W;

  logic [NCHUNK-1:0] c_eq, c_lt;

  for (genvar k = 0; k < NCHUNK; k++) begin : g_chunk
    assign c_eq[k] = a_i[k*CHUNK_W +: CHUNK_W] == b_i[k*CHUNK_W +: CHUNK_W];
    assign c_lt[k] = a_i[k*CHUNK_W +: CHUNK_W] <  b_i[k*CHUNK_W +: CHUNK_W];
  end

  logic lt_u;
  always_comb begin
    lt_u = 1'b0;
    // higher chunk decides unless equal
    for (int k = 0; k < NCHUNK; k++) lt_u = c_lt[k] | (c_eq[k] & lt_u);
  end

  logic sgn_diff;
  assign sgn_diff = a_i[WIDTH-1] ^ b_i[WIDTH-1];
  assign eq_o     = &c_eq;
  assign lt_u_o   = lt_u;
  // differing signs: negative A is smaller
  assign lt_s_o   = sgn_diff ? a_i[WIDTH-1] : lt_u;

  always_comb begin
    // R12
    eq_excl_chk: assert (!(eq_o && (lt_u_o || lt_s_o)))
      else $error("equal operands reported as less-than");
    // R11
    sign_split_chk: assert (sgn_diff || (lt_s_o == lt_u_o))
      else $error("signed and unsigned order differ for same-sign operands");
    // R11
    sign_flip_chk: assert (!sgn_diff || (lt_s_o != lt_u_o))
      else $error("signed and unsigned order agree across the sign boundary");
  end
endmodule

// File: rtl/cmp_cond_sel.sv
module cmp_cond_sel
  import int_cmp_pkg::*;
(
  input  logic [2:0] op_i,
  input  logic       eq_i,
  input  logic       lt_s_i,
  input  logic       lt_u_i,
  output logic       slt_bit_o,
  output logic       taken_o
);
  cmp_op_e op;
  logic    base, is_slt;

  assign op     = cmp_op_e'(op_i);
  assign is_slt = (op == OP_SLT) || (op == OP_SLTU);

  always_comb begin
    base = op_i[2] ? (op_i[1] ? lt_u_i : lt_s_i) : eq_i;
    // odd codes invert the base condition
    taken_o   = is_slt ? 1'b0 : (base ^ op_i[0]);
    slt_bit_o = (op == OP_SLT) ? lt_s_i : ((op == OP_SLTU) ? lt_u_i : 1'b0);
  end

  always_comb begin
    // R4
    quiet_slt_chk: assert (is_slt || !slt_bit_o)
      else $error("slt bit raised for a branch code");
    // R4
    quiet_br_chk: assert (!is_slt || !taken_o)
      else $error("branch flag raised for a set-less-than code");
  end
endmodule

// File: rtl/int_cmp_unit.sv
module int_cmp_unit
  import int_cmp_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int CHUNK_W = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [2:0]      op_i,
  output logic [XLEN-1:0] slt_o,
  output logic            taken_o
);
  logic eq, lt_s, lt_u, slt_bit;

  cmp_magnitude #(.WIDTH(XLEN), .CHUNK_W(CHUNK_W)) u_mag (
    .a_i   (a_i),
    .b_i   (b_i),
    .eq_o  (eq),
    .lt_s_o(lt_s),
    .lt_u_o(lt_u)
  );

  cmp_cond_sel u_sel (
    .op_i     (op_i),
    .eq_i     (eq),
    .lt_s_i   (lt_s),
    .lt_u_i   (lt_u),
    .slt_bit_o(slt_bit),
    .taken_o  (taken_o)
  );

  assign slt_o = {{(XLEN-1){1'b0}}, slt_bit};

  always_comb begin
    // R5
    beq_match_chk: assert (!(op_i == OP_BEQ && taken_o) || (a_i == b_i))
      else $error("equal branch taken on differing operands");
    // R6
    bne_match_chk: assert (!(op_i == OP_BNE && taken_o) || (a_i != b_i))
      else $error("not-equal branch taken on equal operands");
    // R10
    bgeu_eq_chk: assert (!(op_i == OP_BGEU && a_i == b_i) || taken_o)
      else $error("unsigned greater-or-equal not taken on equal operands");
  end
endmodule

// File: tb/int_cmp_unit_tb_top.sv
module int_cmp_unit_tb_top;
  localparam int XLEN = 64;
  localparam logic [XLEN-1:0] MINV = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic [XLEN-1:0] ONES = '1;

  typedef struct packed {
    logic [2:0]      op;
    logic [XLEN-1:0] a;
    logic [XLEN-1:0] b;
    logic            slt;
    logic            tk;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VEC [NVEC] = '{
    '{3'b010, 64'd5, 64'd7, 1'b1, 1'b0},                   // R1
    '{3'b010, 64'd7, 64'd5, 1'b0, 1'b0},                   // R1
    '{3'b010, ONES, 64'd1, 1'b1, 1'b0},                    // R1 -1 < 1
    '{3'b011, ONES, 64'd1, 1'b0, 1'b0},                    // R2
    '{3'b011, 64'd5, ONES, 1'b1, 1'b0},                    // R2 sext imm -1
    '{3'b000, 64'd42, 64'd42, 1'b0, 1'b1},                 // R5
    '{3'b001, 64'd42, 64'd43, 1'b0, 1'b1},                 // R6
    '{3'b100, 64'hFFFF_FFFF_FFFF_FFFD, 64'd2, 1'b0, 1'b1}, // R7
    '{3'b101, 64'd2, 64'hFFFF_FFFF_FFFF_FFFD, 1'b0, 1'b1}, // R8
    '{3'b101, 64'hFFFF_FFFF_FFFF_FFFD, 64'd2, 1'b0, 1'b0}, // R8
    '{3'b110, 64'd2, 64'hFFFF_FFFF_FFFF_FFFD, 1'b0, 1'b1}, // R9
    '{3'b111, 64'hFFFF_FFFF_FFFF_FFFD, 64'd2, 1'b0, 1'b1}, // R10
    '{3'b000, 64'h0000_0100_0000_0000, 64'd0, 1'b0, 1'b0}, // R5
    '{3'b110, 64'h0000_0001_0000_0000, 64'h0000_0000_FFFF_FFFF, 1'b0, 1'b0} // R9 chunk edge
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [XLEN-1:0] a, b, slt;
  logic [2:0]      op;
  logic            taken;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  int_cmp_unit dut_i (
    .a_i    (a),
    .b_i    (b),
    .op_i   (op),
    .slt_o  (slt),
    .taken_o(taken)
  );

  // Independent model written from the requirements.
  function automatic logic [1:0] model(input logic [2:0] o, input logic [XLEN-1:0] x,
                                       input logic [XLEN-1:0] y);
    logic lts, ltu;
    lts = $signed(x) < $signed(y);
    ltu = x < y;
    case (o)
      3'b000:  return {1'b0, x == y};
      3'b001:  return {1'b0, x != y};
      3'b010:  return {lts, 1'b0};
      3'b011:  return {ltu, 1'b0};
      3'b100:  return {1'b0, lts};
      3'b101:  return {1'b0, !lts};
      3'b110:  return {1'b0, ltu};
      default: return {1'b0, !ltu};
    endcase
  endfunction

  task automatic apply_check(input string req, input logic [2:0] o, input logic [XLEN-1:0] x,
                             input logic [XLEN-1:0] y, input logic e_slt, input logic e_tk);
    @(posedge clk);
    op = o; a = x; b = y;
    @(negedge clk);
    n_chk++;
    if (slt !== {{(XLEN-1){1'b0}}, e_slt} || taken !== e_tk) begin
      n_bad++;
      $display("FAIL %s op=%b a=%h b=%h slt=%h taken=%b exp_slt=%b exp_taken=%b",
               req, o, x, y, slt, taken, e_slt, e_tk);
    end
  endtask

  initial begin
    op = 3'b000; a = '0; b = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Idle inputs: zero operands on the equal code. R5 R3
    n_chk++;
    if (slt !== '0 || taken !== 1'b1) begin
      n_bad++;
      $display("FAIL R5 idle slt=%h taken=%b exp_slt=0 exp_taken=1", slt, taken);
    end

    for (int i = 0; i < NVEC; i++)
      apply_check("R1/R2/R5-R10 vector", VEC[i].op, VEC[i].a, VEC[i].b, VEC[i].slt, VEC[i].tk);

    // R11: most negative value against zero, in both orders, every code
    for (int o = 0; o < 8; o++) begin
      logic [1:0] e;
      e = model(3'(o), MINV, '0);
      apply_check("R11", 3'(o), MINV, '0, e[1], e[0]);
      e = model(3'(o), '0, MINV);
      apply_check("R11", 3'(o), '0, MINV, e[1], e[0]);
    end
    apply_check("R11 signed", 3'b010, MINV, '0, 1'b1, 1'b0);
    apply_check("R11 unsigned", 3'b011, MINV, '0, 1'b0, 1'b0);

    // R12: equal operands for every code; R4 and R3 are covered in the same sweep
    for (int o = 0; o < 8; o++) begin
      logic [1:0] e;
      e = model(3'(o), MINV, MINV);
      apply_check("R12 R4 R3", 3'(o), MINV, MINV, e[1], e[0]);
      e = model(3'(o), 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0);
      apply_check("R12", 3'(o), 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, e[1], e[0]);
    end

    // R8 R10: greater-or-equal forms are complements of their less-than partners
    for (int o = 4; o < 8; o++) begin
      logic [1:0] e;
      e = model(3'(o), 64'h8000_0000_0000_0001, 64'h7FFF_FFFF_FFFF_FFFF);
      apply_check("R8/R10 complement", 3'(o), 64'h8000_0000_0000_0001,
                  64'h7FFF_FFFF_FFFF_FFFF, e[1], e[0]);
    end

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule